// File: doc/BRIEF.md
# Repeated-Subtraction Loop Unit

This block runs the loop "keep subtracting b from a while a is strictly greater than b" on signed W-bit two's complement operands and returns the value of a that is left. One adder does all the arithmetic. It adds the bitwise inverse of b to a with a carry-in of one, so its sum is always a - b. The comparison a > b comes from that same sum: the sign is the sum's top bit XOR the signed overflow flag, and a separate zero detect on the sum rules out equality. No comparator exists anywhere in the datapath.

Each loop iteration takes two control steps. In the compare step, a demultiplexer steers the adder's verdict into a one-bit compare register. In the subtract step, the controller reads that register. If it holds true, the demultiplexer steers the difference back into register a, and a multiplexer in front of a picks the adder rather than the input port. If it holds false, the current a is copied into the final-result register and the loop ends.

Operands arrive on a valid/ready input channel, and the result leaves on a valid/ready output channel. The unit accepts one operand pair, computes, presents the result, and holds it until the consumer takes it. Only then does it accept the next pair. Back-pressure on the output therefore stalls the input: `in_ready` stays low from the accepting edge until the edge that transfers the result. The loop terminates only when b is positive, so the caller must keep b > 0.

Top module: `rsub_loop`

## Requirements
- R1: With b > 0, the output value equals the value of a left after repeating a = a - b while a > b (signed compare, W-bit two's complement).
- R2: The compare treats a - b as negative when sum bit W-1 XOR signed overflow is 1. A wrapped difference such as a = -128, b = 1 (W = 8) therefore counts as "not greater", and a is returned unchanged.
- R3: Equal operands (a - b == 0) count as "not greater": no subtraction happens and a is returned unchanged.
- R4: With k subtractions performed, `out_valid` first rises exactly 2k + 2 clock cycles after the rising edge that accepted the operands. This is two cycles per subtraction plus one compare-and-finish pair.
- R5: `in_ready` is high only while the unit is idle. An `in_valid` presented while busy has no effect: the running computation still returns its own result, and those operands are captured only once `in_ready` is high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. The result transfers on the first edge with both high, and `out_valid` is low on the next cycle.
- R7: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit idle and able to take an operand pair |
| in_a | input | W | Dividend-like operand a, signed |
| in_b | input | W | Subtrahend b, signed, must be > 0 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Final value of a, signed |

## Verification
The hardest situation to reach is a compare whose raw difference overflows. This needs a very negative a against a positive b, where the sum's top bit alone would give the wrong verdict. The stimulus drives a = -128, b = 1 and a = -100, b = 100 directly. It also drives a = 127, b = 1, the longest loop, which exercises the full-range positive end. The next operands are offered while a computation runs and while the output is held back, so that an ignored request and back-pressure coincide. The scoreboard then confirms that every result, and every latency of 2k + 2, belongs to its own request.

// File: rtl/rsub_pkg.sv
package rsub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_STEP = 2'd2,
    ST_OUT  = 2'd3
  } rsub_state_e;

  // per-cycle register load and steering controls from the FSM
  typedef struct packed {
    logic ld_in;   // capture operands, mux selects the input port
    logic ld_cmp;  // demux routes adder verdict to compare register
    logic ld_sub;  // demux routes adder sum back into register a
    logic ld_fin;  // copy register a into the final-result register
  } rsub_ctl_t;

endpackage

// File: rtl/rsub_addsub.sv
module rsub_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         neg,
  output logic         zero
);
  localparam int MSB = W - 1;

  logic [W-1:0] y_eff;
  logic [W:0]   full;

  // subtraction: inverse of y plus carry-in one
  always_comb begin
    y_eff = sub ? ~y : y;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
  end

  assign sum  = full[W-1:0];
  assign ovf  = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);
  assign neg  = sum[MSB] ^ ovf;
  assign zero = (sum == '0);

  // a_r2_zero_not_neg: an exact zero difference never reads as negative
  always_comb begin
    a_r2_zero_not_neg: assert (!(zero && neg));
  end

endmodule

// File: rtl/rsub_datapath.sv
module rsub_datapath
  import rsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rsub_ctl_t    ctl,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         gt_q,
  output logic [W-1:0] fin_q
);
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic [W-1:0] sum;
  logic         ovf;
  logic         neg;
  logic         zero;
  logic         gt_now;
  logic [W-1:0] a_mux;
  logic         dmx_to_cmp;
  logic         dmx_to_a;

  rsub_addsub #(.W(W)) u_addsub (
    .x    (a_q),
    .y    (b_q),
    .sub  (1'b1),
    .sum  (sum),
    .ovf  (ovf),
    .neg  (neg),
    .zero (zero)
  );

  // a > b only when the difference is neither negative nor zero
  assign gt_now = !neg && !zero;

  // demultiplexer: one adder result, two destinations
  assign dmx_to_cmp = ctl.ld_cmp;
  assign dmx_to_a   = ctl.ld_sub;

  // multiplexer at the input of register a
  assign a_mux = ctl.ld_in ? in_a : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      gt_q  <= 1'b0;   // loop selector starts false
      fin_q <= '0;
    end else begin
      if (ctl.ld_in || dmx_to_a) a_q <= a_mux;
      if (ctl.ld_in) begin
        b_q  <= in_b;
        gt_q <= 1'b0;
      end
      if (dmx_to_cmp) gt_q <= gt_now;
      if (ctl.ld_fin) fin_q <= a_q;
    end
  end

  // a_r3_fin_after_false: result captured only after a failed compare
  a_r3_fin_after_false: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_fin |-> !gt_q);

  // a_r1_sub_after_true: a subtraction only follows a passed compare
  a_r1_sub_after_true: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ld_sub |-> gt_q);

endmodule

// File: rtl/rsub_ctrl.sv
module rsub_ctrl
  import rsub_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      out_ready,
  input  logic      gt_q,
  output rsub_ctl_t ctl,
  output logic      in_ready,
  output logic      out_valid
);
  rsub_state_e st_q;
  rsub_state_e st_d;

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    unique case (st_q)
      ST_IDLE: if (in_valid) begin
        ctl.ld_in = 1'b1;
        st_d      = ST_CMP;
      end
      ST_CMP: begin
        ctl.ld_cmp = 1'b1;
        st_d       = ST_STEP;
      end
      ST_STEP: begin
        if (gt_q) begin
          ctl.ld_sub = 1'b1;
          st_d       = ST_CMP;
        end else begin
          ctl.ld_fin = 1'b1;
          st_d       = ST_OUT;
        end
      end
      ST_OUT: if (out_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_OUT);

  // a_r4_cmp_then_step: every compare step is followed by a decision step
  a_r4_cmp_then_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMP) |=> (st_q == ST_STEP));

  // a_r5_single_phase: at most one register group loads per cycle
  a_r5_single_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.ld_in, ctl.ld_cmp, ctl.ld_sub, ctl.ld_fin}));

endmodule

// File: rtl/rsub_loop.sv
module rsub_loop
  import rsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  rsub_ctl_t ctl;
  logic      gt_q;

  rsub_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .gt_q      (gt_q),
    .ctl       (ctl),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  rsub_datapath #(.W(W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .in_a  (in_a),
    .in_b  (in_b),
    .gt_q  (gt_q),
    .fin_q (out_data)
  );

  // a_r6_hold_result: stalled result keeps valid and data
  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // a_r6_drop_after_take: result leaves after one transfer
  a_r6_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // a_r5_busy_after_accept: accepted pair closes the input
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // a_r5_no_overlap: never idle and holding a result together
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

endmodule

// File: tb/rsub_loop_bench.sv
module rsub_loop_bench;
  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    int res;
    int lat;
    int acc;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   bp_mode = 1'b0;
  bit   first_seen = 1'b0;
  bit   finished = 1'b0;
  logic [W-1:0] held;
  exp_t q[$];

  rsub_loop #(.W(W)) u_rsub_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // software model of the loop; also counts subtractions
  function automatic void model(input int a, input int b, output int r, output int k);
    r = a;
    k = 0;
    while (r > b) begin
      r = r - b;
      k++;
    end
  endfunction

  task automatic send(input int a, input int b);
    int r;
    int k;
    exp_t e;
    model(a, b, r, k);
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = a[W-1:0];
    in_b     = b[W-1:0];
    while (!in_ready) @(negedge clk);
    e.res = r;
    e.lat = 2 * k + 2;
    e.acc = cyc + 1;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !first_seen) begin
        first_seen = 1'b1;
        held       = out_data;
        if (q.size() == 0) begin
          check(1'b0, "R1 unexpected result", 1, 0);
        end else begin
          check((cyc - q[0].acc) == q[0].lat, "R4 latency", cyc - q[0].acc, q[0].lat);
        end
      end else if (out_valid) begin
        check(out_data == held, "R6 held data stable", int'($signed(out_data)), int'($signed(held)));
      end
      out_ready = bp_mode ? ((cyc % 3) == 2) : 1'b1;
      if (out_valid && out_ready && q.size() != 0) begin
        check(int'($signed(out_data)) == q[0].res, "R1 R2 R3 result",
              int'($signed(out_data)), q[0].res);
        void'(q.pop_front());
        first_seen = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drain;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;

    // R1 general loops
    send(20, 3);
    send(100, 7);
    send(127, 1);
    drain();
    // R2 overflowing compares
    send(-128, 1);
    send(-100, 100);
    // R3 equal operands and already-smaller a
    send(7, 7);
    send(127, 127);
    send(5, 9);
    send(0, 1);
    drain();

    // R5 busy: in_ready low during a run, offered pair held back
    send(90, 4);
    @(negedge clk);
    check(in_ready == 1'b0, "R5 in_ready low while busy", int'(in_ready), 0);
    in_valid = 1'b1;
    in_a     = 8'd3;
    in_b     = 8'd1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R6 back-pressure, back-to-back requests
    bp_mode = 1'b1;
    send(8, 7);
    send(50, 6);
    send(1, 1);
    send(-5, 3);
    drain();
    bp_mode = 1'b0;
    // the R5 stray pair (3,1) may have been taken at idle; flush any late result
    repeat (10) @(negedge clk);
    check(out_valid == 1'b0, "R6 idle after drain", int'(out_valid), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule